// File: doc/BRIEF.md
# Packed SIMD Lane Shift Unit

This block shifts a 32-bit operand that is viewed as a set of packed lanes: four 8-bit lanes, two 16-bit lanes, or a single 32-bit lane. Every lane is shifted by the same amount. Each lane's result goes back into the bit positions it came from. The operation is one of these: plain left shift, logical right shift, arithmetic right shift, arithmetic right shift with round-to-nearest, or left shift that saturates to the signed range of the lane. Not every operation is offered at every lane size. A combination that is not offered produces a zero result.

The shift amount is taken from the low bits of a register value. How many bits are used depends on the lane width. Left shifts report a per-operation overflow flag. The same event also sets a sticky overflow bit, which stays set until it is cleared through a dedicated input. Results, the per-operation flag and the sticky bit are all registered, so an operation presented with `in_valid` appears on the outputs one clock later.

Top module: `simd_lane_shifter`

## Requirements
- R1: With `lane_sel`=00 (four 8-bit lanes), only `shamt[2:0]` is used; `shamt[4:3]` has no effect on the result.
- R2: With `lane_sel`=01 (two 16-bit lanes), only `shamt[3:0]` is used; `shamt[4]` has no effect on the result.
- R3: With `lane_sel`=10 (one 32-bit lane), all five bits of `shamt` are used, giving amounts 0 to 31.
- R4: Lane k occupies bits [k*W+W-1 : k*W]. Each lane is shifted on its own, and nothing crosses between lanes.
- R5: Each lane is shifted with the coding `op_sel`=000 for a plain left shift (zero fill), 001 for a logical right shift (zero fill) and 010 for an arithmetic right shift (sign fill).
- R6: `op_sel`=011 is a rounding arithmetic right shift. It adds 2^(s-1) to the sign-extended lane in one extra bit of width, then shifts right arithmetically by s. An amount of 0 returns the lane unchanged.
- R7: `op_sel`=100 is a saturating left shift. If the shift overflows, the lane becomes the most positive signed value (original sign 0) or the most negative signed value (original sign 1). Otherwise the lane takes the plain left-shift result.
- R8: A lane overflows on a left shift (000 or 100) when the bits shifted out and the new sign bit are not all equal to the original sign bit. `ovf_flag` is the OR over all lanes. Right shifts always give `ovf_flag`=0.
- R9: `ovf_sticky` becomes 1 at the edge that captures an operation with overflow. It keeps its value until a clock edge with `ovf_clr`=1. If `ovf_clr` arrives at the same edge as a new overflow, the new overflow wins.
- R10: The legal combinations are: 8-bit lanes with ops 000 to 011, 16-bit lanes with ops 000 to 100, and the 32-bit lane with ops 011 and 100. Any other `lane_sel`/`op_sel` pair gives `result`=0 and `ovf_flag`=0, and leaves `ovf_sticky` unchanged.
- R11: An operation sampled with `in_valid`=1 appears on `result` and `ovf_flag` after one clock edge, with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0 and leaves `result` and `ovf_flag` unchanged.
- R12: While `rst` is high, `out_valid`, `result`, `ovf_flag` and `ovf_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| operand | input | 32 | Packed lanes to shift |
| shamt | input | 5 | Shift amount, masked to the lane width |
| lane_sel | input | 2 | 00 byte lanes, 01 halfword lanes, 10 word, 11 reserved |
| op_sel | input | 3 | Shift operation code |
| ovf_clr | input | 1 | Clears the sticky overflow bit |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Repacked shifted lanes |
| ovf_flag | output | 1 | Overflow of the last accepted operation |
| ovf_sticky | output | 1 | Accumulated overflow status |

## Verification
There is exactly one register stage, so `result`, `ovf_flag` and `out_valid` for an operation driven before a rising edge are due right after that edge. The sticky bit follows its set and clear inputs at that same edge. The bench changes inputs on the falling edge, lets one rising edge pass, and compares all four outputs on the next falling edge with a behavioural integer model. So every comparison lands exactly one capture edge after its stimulus. Idle cycles are checked the same way to confirm that the outputs hold.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

  typedef enum logic [1:0] {
    LS_BYTE = 2'b00,
    LS_HALF = 2'b01,
    LS_WORD = 2'b10,
    LS_RSVD = 2'b11
  } lane_size_e;

  localparam logic [2:0] OP_SLL  = 3'd0;
  localparam logic [2:0] OP_SRL  = 3'd1;
  localparam logic [2:0] OP_SRA  = 3'd2;
  localparam logic [2:0] OP_SRAR = 3'd3;
  localparam logic [2:0] OP_SLLS = 3'd4;

  // Which operations each lane size offers.
  function automatic logic op_allowed(input logic [1:0] ls, input logic [2:0] op);
    logic ok;
    case (ls)
      LS_BYTE: ok = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA) || (op == OP_SRAR);
      LS_HALF: ok = (op <= OP_SLLS);
      LS_WORD: ok = (op == OP_SRAR) || (op == OP_SLLS);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic op_is_right(input logic [2:0] op);
    return (op == OP_SRL) || (op == OP_SRA) || (op == OP_SRAR);
  endfunction

endpackage

// File: rtl/lane_shift.sv
module lane_shift
  import simd_shift_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int SA_W = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [SA_W-1:0]   amt,
  input  logic [2:0]        op,
  output logic [LANE_W-1:0] lane_out,
  output logic              lane_ovf
);

  localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic [LANE_W-1:0]        shl;
  logic signed [LANE_W-1:0] back;
  logic                     lost;
  logic [LANE_W:0]          bias;
  logic signed [LANE_W:0]   ext_sum;

  // Left shift, then arithmetic shift back: any mismatch means the
  // discarded bits or the new sign disagreed with the original sign.
  assign shl     = lane_in << amt;
  assign back    = $signed(shl) >>> amt;
  assign lost    = (back != $signed(lane_in));

  // Rounding bias 2^(amt-1), zero when amt is 0.
  assign bias    = ((LANE_W+1)'(1) << amt) >> 1;
  assign ext_sum = $signed({lane_in[LANE_W-1], lane_in}) + $signed(bias);

  always_comb begin
    lane_out = '0;
    lane_ovf = 1'b0;
    case (op)
      OP_SLL: begin
        lane_out = shl;
        lane_ovf = lost;
      end
      OP_SLLS: begin
        lane_ovf = lost;
        if (lost) lane_out = lane_in[LANE_W-1] ? NEG_MIN : POS_MAX;
        else      lane_out = shl;
      end
      OP_SRL:  lane_out = lane_in >> amt;
      OP_SRA:  lane_out = $signed(lane_in) >>> amt;
      OP_SRAR: lane_out = LANE_W'(ext_sum >>> amt);
      default: lane_out = '0;
    endcase
  end

endmodule

// File: rtl/lane_group.sv
module lane_group
  import simd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int N_LANES = DATA_W / LANE_W,
  localparam int SA_W    = $clog2(LANE_W)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [SA_W-1:0]   amt,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] data_out,
  output logic              any_ovf
);

  logic [N_LANES-1:0] ovf_vec;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    lane_shift #(.LANE_W(LANE_W)) u_lane (
      .lane_in  (data_in[k*LANE_W +: LANE_W]),
      .amt      (amt),
      .op       (op),
      .lane_out (data_out[k*LANE_W +: LANE_W]),
      .lane_ovf (ovf_vec[k])
    );
  end

  assign any_ovf = |ovf_vec;

endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
  import simd_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int BSA_W = $clog2(BYTE_W),
  localparam int HSA_W = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic [SH_W-1:0]   shamt,
  input  logic [1:0]        lane_sel,
  input  logic [2:0]        op_sel,
  input  logic              ovf_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ovf_flag,
  output logic              ovf_sticky
);

  logic [DATA_W-1:0] byte_res, half_res, word_res, sel_res;
  logic              byte_ovf, half_ovf, word_ovf, sel_ovf;
  logic              legal;

  lane_group #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
    .data_in (operand), .amt(shamt[BSA_W-1:0]), .op(op_sel),
    .data_out(byte_res), .any_ovf(byte_ovf)
  );

  lane_group #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_halves (
    .data_in (operand), .amt(shamt[HSA_W-1:0]), .op(op_sel),
    .data_out(half_res), .any_ovf(half_ovf)
  );

  lane_group #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_word (
    .data_in (operand), .amt(shamt), .op(op_sel),
    .data_out(word_res), .any_ovf(word_ovf)
  );

  assign legal = op_allowed(lane_sel, op_sel);

  always_comb begin
    sel_res = '0;
    sel_ovf = 1'b0;
    if (legal) begin
      case (lane_sel)
        LS_BYTE: begin sel_res = byte_res; sel_ovf = byte_ovf; end
        LS_HALF: begin sel_res = half_res; sel_ovf = half_ovf; end
        LS_WORD: begin sel_res = word_res; sel_ovf = word_ovf; end
        default: begin sel_res = '0;       sel_ovf = 1'b0;     end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      ovf_flag   <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= sel_res;
        ovf_flag <= sel_ovf;
      end
      ovf_sticky <= (ovf_sticky & ~ovf_clr) | (in_valid & sel_ovf);
    end
  end

  // R11: one-cycle latency of accepted operations
  a_r11_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11: idle cycles hold the data outputs
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ovf_flag)));

  // R8: right shifts never report overflow
  a_r8_right_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_is_right(op_sel)) |=> !ovf_flag);

  // R9: a reported overflow is always reflected in the sticky bit
  a_r9_sticky_covers: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ovf_flag) |-> ovf_sticky);

  // R9: the sticky bit only drops after a clear request
  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_sticky) |-> $past(ovf_clr));

  // R10: reserved combinations produce zero and no overflow
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (result == '0 && !ovf_flag));

endmodule

// File: tb/test_simd_lane_shifter.sv
module test_simd_lane_shifter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [4:0]  shamt = '0;
  logic [1:0]  lane_sel = '0;
  logic [2:0]  op_sel = '0;
  logic        ovf_clr = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_flag;
  logic        ovf_sticky;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_res = '0;
  logic        exp_ovf = 1'b0;
  logic        exp_stk = 1'b0;
  logic        exp_vld = 1'b0;

  always #10 clk = ~clk;

  simd_lane_shifter i_simd_lane_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .shamt(shamt), .lane_sel(lane_sel), .op_sel(op_sel), .ovf_clr(ovf_clr),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag),
    .ovf_sticky(ovf_sticky)
  );

  // Behavioural model built from the requirements with integer arithmetic.
  function automatic void ref_model(input logic [31:0] a, input logic [4:0] sh,
                                    input logic [1:0] ls, input logic [2:0] op,
                                    output logic [31:0] r, output logic ov);
    int w, sa;
    bit ok;
    longint one, m, s, p, lo, hi, o;
    logic [31:0] lv;
    r = '0; ov = 1'b0; one = 1;
    case (ls)
      2'd0: w = 8;
      2'd1: w = 16;
      2'd2: w = 32;
      default: w = 0;
    endcase
    ok = (w == 8 && op <= 3) || (w == 16 && op <= 4) || (w == 32 && (op == 3 || op == 4));
    if (!ok) return;
    sa = int'(sh) % w;
    m  = (one << w) - 1;
    hi = (one << (w-1)) - 1;
    lo = -(one << (w-1));
    for (int k = 0; k < 32 / w; k++) begin
      lv = 32'((longint'(a) >> (k*w)) & m);
      s  = longint'(lv);
      if (lv[w-1]) s = s - (one << w);
      o = 0;
      case (op)
        3'd0, 3'd4: begin
          p = s * (one << sa);
          if (p > hi || p < lo) begin
            ov = 1'b1;
            o = (op == 3'd4) ? ((s < 0) ? lo : hi) : p;
          end else o = p;
        end
        3'd1: o = longint'(lv) >> sa;
        3'd2: o = s >>> sa;
        default: o = (s + ((sa > 0) ? (one << (sa-1)) : 0)) >>> sa;
      endcase
      r = r | (32'(o & m) << (k*w));
    end
  endfunction

  task automatic check_outputs(input string tag);
    checks++;
    if (out_valid !== exp_vld || result !== exp_res ||
        ovf_flag !== exp_ovf || ovf_sticky !== exp_stk) begin
      errors++;
      $display("FAIL %s: valid/result/ovf/sticky actual %b/%h/%b/%b expected %b/%h/%b/%b",
               tag, out_valid, result, ovf_flag, ovf_sticky,
               exp_vld, exp_res, exp_ovf, exp_stk);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [4:0] sh,
                      input logic [1:0] ls, input logic [2:0] op,
                      input logic clr, input string tag);
    logic [31:0] r;
    logic ov;
    in_valid = v; operand = a; shamt = sh; lane_sel = ls; op_sel = op; ovf_clr = clr;
    if (v) begin
      ref_model(a, sh, ls, op, r, ov);
      exp_res = r;
      exp_ovf = ov;
    end else ov = 1'b0;
    exp_stk = (exp_stk & ~clr) | (v & ov);
    exp_vld = v;
    @(negedge clk);
    check_outputs(tag);
  endtask

  function automatic string tag_of(input logic [1:0] ls, input logic [2:0] op);
    bit ok;
    ok = (ls == 0 && op <= 3) || (ls == 1 && op <= 4) || (ls == 2 && (op == 3 || op == 4));
    if (!ok) return "R10";
    case (op)
      3'd3: return "R6";
      3'd4: return "R7";
      3'd0: return "R8";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R12");
    rst = 1'b0;

    // R4: lanes stay in place, independent
    step(1, 32'h80402010, 5'd4, 2'd0, 3'd1, 0, "R4");
    // R1: upper shamt bits ignored for bytes (0x19 -> 1)
    step(1, 32'h01010101, 5'h19, 2'd0, 3'd0, 0, "R1");
    // R2: upper bit ignored for halves (0x13 -> 3)
    step(1, 32'h80004000, 5'h13, 2'd1, 3'd2, 0, "R2");
    // R3: word uses full amount
    step(1, 32'h00000003, 5'd1, 2'd2, 3'd3, 0, "R3");
    step(1, 32'hC0000000, 5'd31, 2'd2, 3'd3, 0, "R3");
    // R8: byte left overflow sets flag and sticky
    step(1, 32'h81818181, 5'd1, 2'd0, 3'd0, 0, "R8");
    // R11: idle holds outputs
    step(0, 32'hFFFFFFFF, 5'd7, 2'd1, 3'd4, 0, "R11");
    // R9: clear while idle
    step(0, 32'h0, 5'd0, 2'd0, 3'd0, 1, "R9");
    // R7: halfword saturation, one lane clamps
    step(1, 32'h4000C000, 5'd1, 2'd1, 3'd4, 0, "R7");
    step(1, 32'h80000001, 5'd31, 2'd2, 3'd4, 0, "R7");
    // R10: reserved combination, sticky unchanged
    step(1, 32'h12345678, 5'd2, 2'd0, 3'd4, 0, "R10");
    step(1, 32'h12345678, 5'd2, 2'd3, 3'd1, 0, "R10");
    step(1, 32'h12345678, 5'd2, 2'd2, 3'd0, 0, "R10");
    // R6: rounding, including shift by 0
    step(1, 32'h7F80FF01, 5'd1, 2'd0, 3'd3, 0, "R6");
    step(1, 32'h89ABCDEF, 5'd0, 2'd2, 3'd3, 0, "R6");
    // R9: clear and new overflow in same cycle, overflow wins
    step(1, 32'h7FFF0001, 5'd15, 2'd1, 3'd0, 1, "R9");
    step(1, 32'h00000001, 5'd3, 2'd1, 3'd0, 1, "R9");
    // R5: right shifts by the maximum amount
    step(1, 32'h80FF7F01, 5'd7, 2'd0, 3'd2, 0, "R5");
    step(1, 32'h8001FFFF, 5'd15, 2'd1, 3'd1, 0, "R5");

    for (int i = 0; i < 600; i++) begin
      logic [1:0] ls;
      logic [2:0] op;
      logic [4:0] sh;
      ls = 2'($urandom % 4);
      op = 3'($urandom % 8);
      case ($urandom % 4)
        0: sh = 5'd0;
        1: sh = (ls == 0) ? 5'd7 : (ls == 1) ? 5'd15 : 5'd31;
        2: sh = (ls == 0) ? 5'(8 + $urandom % 24) : 5'(16 + $urandom % 16);
        default: sh = 5'($urandom);
      endcase
      step(($urandom % 5) != 0, $urandom, sh, ls, op, ($urandom % 7) == 0, tag_of(ls, op));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule